// File: doc/BRIEF.md
# Serial Port Modem Control and Loopback

This block is the modem handshake section of a byte-oriented asynchronous serial port. It holds a five-bit control register: data-terminal-ready, request-to-send, a pin-less user flag, an interrupt pin enable and a local loopback switch. It also builds an eight-bit status byte. The upper nibble of that byte reports the present state of the four modem inputs. The lower nibble holds sticky change flags that a read of the status byte clears.

In normal operation the control bits drive the active-low DTR and RTS pins. The external modem inputs pass through a synchronizer before they reach the status byte. Serial data flows straight between the pins and the shift-register taps. With loopback set, the block detaches the port from the outside world for a self-test. The transmit pin idles at the mark level, and the transmit shift output is fed to the receive shift input. The DTR and RTS pins go inactive. The four control bits are reflected into the status nibble in place of the external inputs, so software can raise modem-status interrupts by writing the control register. The interrupt pin is released (output enable low) whenever loopback is on or the interrupt pin enable is off.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 00h. dtr_n and rts_n are 1, irq_oe is 0, msr_int is 0, and with all modem pins high the status byte reads 00h.
- R2: A write with mcr_we stores mcr_wdata[4:0] (bit0 DTR, bit1 RTS, bit2 OUT1, bit3 interrupt pin enable, bit4 loopback), visible on mcr_rdata after the write edge. Bits 7:5 always read 0.
- R3: With loopback off, dtr_n equals the inverse of control bit0 and rts_n equals the inverse of control bit1.
- R4: With loopback off, sout follows tx_shift_out and rx_shift_in follows sin.
- R5: With loopback on, sout is 1 whatever tx_shift_out is. rx_shift_in follows tx_shift_out, and sin has no effect.
- R6: With loopback on, dtr_n and rts_n are 1 and the external modem pins have no effect on the status byte.
- R7: With loopback on, status bits 7:4 are control bit3, bit2, bit0 and bit1 respectively (DCD, RI, DSR, CTS) in the cycle after the write.
- R8: With loopback off, status bits 4, 5, 6 and 7 are the inverse of cts_n, dsr_n, ri_n and dcd_n. A pin change at a clock edge shows in the status byte after the second following rising edge.
- R9: Status bit0 sets when the CTS status bit changes, bit1 when DSR changes, and bit3 when DCD changes. Bit2 sets when RI goes from 1 to 0. Each sets on the edge after its status bit changes. msr_int is the OR of bits 3:0.
- R10: A cycle with msr_re returns the status byte unchanged that cycle and clears bits 3:0 on the next edge, unless a new change sets them on that edge.
- R11: irq_oe is 1 only when control bit3 is 1 and loopback is off. irq follows irq_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcr_we | input | 1 | Control register write strobe |
| mcr_wdata | input | 8 | Control register write data |
| mcr_rdata | output | 8 | Control register read value |
| msr_re | input | 1 | Status byte read strobe (clears change flags) |
| msr_rdata | output | 8 | Status byte |
| msr_int | output | 1 | Modem status interrupt request |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_shift_out | input | 1 | Transmit shift register output tap |
| rx_shift_in | output | 1 | Receive shift register input tap |
| sin | input | 1 | Serial data input pin |
| sout | output | 1 | Serial data output pin |
| irq_req | input | 1 | Port interrupt request from the interrupt logic |
| irq | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output enable (0 = high impedance) |

## Verification
The bench checks that the external pin path has exactly two synchronizer stages and one more edge before the change flag. A design with a stage too few or too many would fail the cycle-exact status checks. The bench drives RI in both directions to catch a ring flag that fires on the leading edge instead of the trailing one. In loopback it permutes the control bits into the status nibble and asserts the external pins. Swapped DSR/CTS wiring or a leaking pin would then show a wrong status byte. It also checks that the interrupt pin stays released with the enable bit set in loopback, and that a status read clears the flags only on the following edge.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcr_we,
  input  logic [7:0] mcr_wdata,
  output logic [7:0] mcr_rdata,
  input  logic       msr_re,
  output logic [7:0] msr_rdata,
  output logic       msr_int,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  input  logic       tx_shift_out,
  output logic       rx_shift_in,
  input  logic       sin,
  output logic       sout,
  input  logic       irq_req,
  output logic       irq,
  output logic       irq_oe
);

  localparam int CTL_W = 5;
  localparam int MDM_W = 4;

  logic [CTL_W-1:0] ctl;
  logic             loop_on, pin_ie, out1, rts_bit, dtr_bit;
  logic [MDM_W-1:0] sync_q [SYNC_STAGES];
  logic [MDM_W-1:0] ext_st, lb_st, cur_st, prev_st, delta, hit;
  logic             unused_rsvd;

  assign unused_rsvd = ^mcr_wdata[7:CTL_W];

  assign {loop_on, pin_ie, out1, rts_bit, dtr_bit} = ctl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (mcr_we) ctl <= mcr_wdata[CTL_W-1:0];

  assign mcr_rdata = {{(8-CTL_W){1'b0}}, ctl};

  // status nibble order: {dcd, ri, dsr, cts}
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= ~{dcd_n, ri_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign ext_st = sync_q[SYNC_STAGES-1];
  assign lb_st  = {pin_ie, out1, dtr_bit, rts_bit};
  assign cur_st = loop_on ? lb_st : ext_st;

  assign hit = {cur_st[3] ^ prev_st[3],
                prev_st[2] & ~cur_st[2],
                cur_st[1] ^ prev_st[1],
                cur_st[0] ^ prev_st[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_st <= '0;
      delta   <= '0;
    end else begin
      prev_st <= cur_st;
      delta   <= (msr_re ? '0 : delta) | hit;
    end

  assign msr_rdata = {cur_st, delta};
  assign msr_int   = |delta;

  assign dtr_n       = loop_on | ~dtr_bit;
  assign rts_n       = loop_on | ~rts_bit;
  assign sout        = loop_on | tx_shift_out;
  assign rx_shift_in = loop_on ? tx_shift_out : sin;

  assign irq    = irq_req;
  assign irq_oe = pin_ie & ~loop_on;

endmodule

module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mcr_we,
  input logic [7:0] mcr_wdata,
  input logic [7:0] mcr_rdata,
  input logic       msr_re,
  input logic [7:0] msr_rdata,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       tx_shift_out,
  input logic       rx_shift_in,
  input logic       sout,
  input logic       irq_req,
  input logic       irq,
  input logic       irq_oe
);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_rdata[7:5] == 3'b000);

  assert_pin_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_we && !mcr_wdata[4]) |=> (dtr_n == !$past(mcr_wdata[0])) && (rts_n == !$past(mcr_wdata[1])));

  assert_lb_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_rdata[4] |-> sout && (rx_shift_in == tx_shift_out));

  assert_lb_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_rdata[4] |-> dtr_n && rts_n);

  assert_lb_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_we && mcr_wdata[4]) |=> msr_rdata[7:4] ==
      {$past(mcr_wdata[3]), $past(mcr_wdata[2]), $past(mcr_wdata[0]), $past(mcr_wdata[1])});

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_re && $stable(msr_rdata[7:4])) |=> msr_rdata[3:0] == 4'h0);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> mcr_rdata[3] && !mcr_rdata[4] && (irq == irq_req));

endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
  .mcr_rdata(mcr_rdata), .msr_re(msr_re), .msr_rdata(msr_rdata),
  .dtr_n(dtr_n), .rts_n(rts_n), .tx_shift_out(tx_shift_out),
  .rx_shift_in(rx_shift_in), .sout(sout), .irq_req(irq_req),
  .irq(irq), .irq_oe(irq_oe)
);

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;

  logic clk = 0, rst_n = 0;
  logic mcr_we = 0, msr_re = 0;
  logic [7:0] mcr_wdata = 0;
  logic [7:0] mcr_rdata, msr_rdata;
  logic msr_int, dtr_n, rts_n, rx_shift_in, sout, irq, irq_oe;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic tx_shift_out = 1, sin = 1, irq_req = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_modem_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
    .mcr_rdata(mcr_rdata), .msr_re(msr_re), .msr_rdata(msr_rdata),
    .msr_int(msr_int), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n), .tx_shift_out(tx_shift_out),
    .rx_shift_in(rx_shift_in), .sin(sin), .sout(sout), .irq_req(irq_req),
    .irq(irq), .irq_oe(irq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_mcr(input logic [7:0] v);
    mcr_we = 1; mcr_wdata = v;
    @(negedge clk);
    mcr_we = 0;
  endtask

  task automatic rd_msr(output logic [7:0] v);
    v = msr_rdata;
    msr_re = 1;
    @(negedge clk);
    msr_re = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 mcr", mcr_rdata, 8'h00);
    chk("R1 pins", {6'b0, dtr_n, rts_n}, 8'h03);
    chk("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
    chk("R1 msr", msr_rdata, 8'h00);
    chk("R1 int", {7'b0, msr_int}, 8'h00);
  endtask

  task automatic t_ctl_rw;
    wr_mcr(8'hEF);
    chk("R2 rsvd", mcr_rdata, 8'h0F);
    chk("R3 pins on", {6'b0, dtr_n, rts_n}, 8'h00);
    chk("R11 oe on", {7'b0, irq_oe}, 8'h01);
    irq_req = 1; #1;
    chk("R11 irq hi", {7'b0, irq}, 8'h01);
    irq_req = 0; #1;
    chk("R11 irq lo", {7'b0, irq}, 8'h00);
    wr_mcr(8'h02);
    chk("R2 rd", mcr_rdata, 8'h02);
    chk("R3 pins mix", {6'b0, dtr_n, rts_n}, 8'h02);
    chk("R11 oe off", {7'b0, irq_oe}, 8'h00);
    wr_mcr(8'h00);
  endtask

  task automatic t_norm_data;
    tx_shift_out = 0; sin = 0; #1;
    chk("R4 sout0", {7'b0, sout}, 8'h00);
    chk("R4 rx0", {7'b0, rx_shift_in}, 8'h00);
    tx_shift_out = 1; sin = 1; #1;
    chk("R4 sout1", {7'b0, sout}, 8'h01);
    chk("R4 rx1", {7'b0, rx_shift_in}, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_ext_status;
    logic [7:0] v;
    cts_n = 0;
    wait_n(1); chk("R8 stage1", msr_rdata, 8'h00);
    wait_n(1); chk("R8 stage2", msr_rdata, 8'h10);
    wait_n(1); chk("R9 dcts", msr_rdata, 8'h11);
    chk("R9 int", {7'b0, msr_int}, 8'h01);
    rd_msr(v);
    chk("R10 read val", v, 8'h11);
    chk("R10 cleared", msr_rdata, 8'h10);
    chk("R10 int off", {7'b0, msr_int}, 8'h00);
    dsr_n = 0; dcd_n = 0;
    wait_n(3); chk("R9 ddsr ddcd", msr_rdata, 8'hBA);
    rd_msr(v);
    ri_n = 0;
    wait_n(3); chk("R9 ri lead", msr_rdata, 8'hF0);
    ri_n = 1;
    wait_n(3); chk("R9 teri", msr_rdata, 8'hB4);
    rd_msr(v);
    cts_n = 1; dsr_n = 1; dcd_n = 1;
    wait_n(3); chk("R9 falls", msr_rdata, 8'h0B);
    rd_msr(v);
    chk("R10 idle", msr_rdata, 8'h00);
  endtask

  task automatic t_loopback;
    logic [7:0] v;
    wr_mcr(8'h10);
    chk("R6 pins", {6'b0, dtr_n, rts_n}, 8'h03);
    tx_shift_out = 0; sin = 1; #1;
    chk("R5 sout mark", {7'b0, sout}, 8'h01);
    chk("R5 rx tx0", {7'b0, rx_shift_in}, 8'h00);
    tx_shift_out = 1; sin = 0; #1;
    chk("R5 rx tx1", {7'b0, rx_shift_in}, 8'h01);
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0;
    wait_n(4); chk("R6 ext ignored", msr_rdata, 8'h00);
    wr_mcr(8'h11);
    chk("R7 dtr->dsr", msr_rdata, 8'h20);
    chk("R6 dtr pin", {7'b0, dtr_n}, 8'h01);
    wait_n(1); chk("R9 lb delta", msr_rdata, 8'h22);
    rd_msr(v);
    wr_mcr(8'h1F);
    chk("R11 lb oe", {7'b0, irq_oe}, 8'h00);
    wait_n(1); chk("R7 all", msr_rdata, 8'hF9);
    rd_msr(v);
    wr_mcr(8'h1B);
    wait_n(1); chk("R9 lb teri", msr_rdata, 8'hB4);
    rd_msr(v);
    wr_mcr(8'h00);
    wait_n(1); chk("R8 back ext", msr_rdata, 8'hF0);
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1;
    wait_n(3); chk("R9 restore", msr_rdata, 8'h0F);
    rd_msr(v);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    t_reset;
    t_ctl_rw;
    t_norm_data;
    t_ext_status;
    t_loopback;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule